// File: doc/BRIEF.md
# Shadow-Backed Static Memory with Store and Recall

This block is a clocked model of a 2048-byte static memory that carries a second array of the same size acting as nonvolatile backup. Four active-low control pins (chip select, output enable, write strobe and a backup-select pin) are looked at on every clock and decoded into plain reads and writes, or into two bulk commands. Save copies the whole working memory into the backup array. Restore copies the backup array into the working memory. The data output comes with an enable flag that stands in for a tri-state driver.

Save and restore each start with a wipe phase of `ERASE_CYCLES` clocks. A copy phase follows that moves one byte per clock over the whole address space. The `busy` flag is high for the whole sequence, and during that time every pin is ignored and the output stays dark. A bulk command starts only when the pins enter its pattern. The supply-status inputs force a restore: a low-supply pulse arms a request, and the next good-supply indication runs the restore. Until it completes, no access is accepted.

Top module: `nvsram_top`

## Requirements
- R1: With csN=0, oeN=0, weN=1, bkN=1, while the block is neither busy nor holding a restore request, doutEn is 1 and dout shows the working byte at addr, following addr in the same cycle.
- R2: With csN=0, weN=0, bkN=1 and the block free, din is written to the working byte at addr on the clock edge. doutEn stays 0 during such a write whatever oeN is.
- R3: When csN=1, or when the pins decode to no operation, doutEn is 0, dout is 0x00 and nothing is written.
- R4: The pattern csN=0, oeN=1, weN=0, bkN=0 starts a save: the backup array is wiped to 0x00, then every working byte is copied into it. busy is high for exactly ERASE_CYCLES + 2048 clocks.
- R5: The pattern csN=0, oeN=0, weN=1, bkN=0 starts a restore: the working array is cleared to 0x00, then every backup byte is copied into it. busy is high for exactly ERASE_CYCLES + 2048 clocks. The backup array is left unchanged, so restores may be repeated.
- R6: A save or restore starts only on the clock where the pins enter its pattern. Holding the pattern during or after the operation starts nothing more, and a pattern already present at reset release starts nothing.
- R7: While busy is high, doutEn is 0 and dout is 0x00, and all pin activity, including writes, has no effect.
- R8: On the first clock after busy falls, the read or write pattern then on the pins takes effect at once. A read turns doutEn on in that cycle.
- R9: A clock with supplyLow=1 arms a restore request. While it is armed, no read or write is accepted. The first clock with supplyGood=1 and supplyLow=0 while the block is free starts a restore, without any pin transition.
- R10: Synchronous active-high reset leaves busy=0, arms the restore request and loads backup byte i with (i mod 256) XOR 0xA5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write strobe, active low |
| bkN | input | 1 | Backup-array select, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| supplyLow | input | 1 | Supply-below-threshold indication |
| supplyGood | input | 1 | Supply-recovered indication |
| dout | output | 8 | Read data, 0x00 when not driving |
| doutEn | output | 1 | Output driver on |
| busy | output | 1 | Save or restore sequence running |

## Verification
A vector table tries reads at the lowest, highest and a middle address. Writes are applied with output enable both high and low, so write muting is kept apart from read decode. Deselected and undecodable pin patterns are included to show that they neither drive nor write. Directed runs then save with the pattern held past completion, which separates edge triggering from level triggering. Restores are repeated over modified working data, which shows that backup contents survive. Inside a save, writes and a read are issued to show the lock-out and the immediate read at completion. A supply dip with read pins held shows the blocked access and the automatic restore.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIPE_BK,
    ST_SAVE,
    ST_WIPE_WK,
    ST_LOAD
  } seqState_t;

  // strobes from the sequencer to the arrays
  typedef struct packed {
    logic wkWrite;   // pin write into working array
    logic wkWipe;    // clear working array
    logic bkWipe;    // clear backup array
    logic saveByte;  // working -> backup at xferAddr
    logic loadByte;  // backup -> working at xferAddr
  } dpStrobe_t;

endpackage

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int ERASE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              bkN,
  input  logic              supplyLow,
  input  logic              supplyGood,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] xferAddr,
  output logic              readOn,
  output logic              busy,
  output logic              pendingRecall
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SPAN  = (DEPTH > ERASE_CYCLES) ? DEPTH : ERASE_CYCLES;
  localparam int CNT_W = $clog2(SPAN);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             prevSave, prevLoad;

  logic isRead, isWrite, isSave, isLoad;
  logic idle, blocked, autoGo, saveGo, loadGo;
  logic wipeDone, copyDone;

  // pin decode
  always_comb begin
    isRead  = !csN && !oeN &&  weN &&  bkN;
    isWrite = !csN && !weN &&  bkN;
    isSave  = !csN &&  oeN && !weN && !bkN;
    isLoad  = !csN && !oeN &&  weN && !bkN;
  end

  always_comb begin
    idle     = (state == ST_IDLE);
    blocked  = !idle || pendingRecall;
    autoGo   = idle && pendingRecall && supplyGood && !supplyLow;
    saveGo   = idle && !pendingRecall && isSave && !prevSave;
    loadGo   = idle && !pendingRecall && isLoad && !prevLoad;
    wipeDone = (cnt == CNT_W'(ERASE_CYCLES - 1));
    copyDone = (cnt == CNT_W'(DEPTH - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      prevSave      <= 1'b1;
      prevLoad      <= 1'b1;
      pendingRecall <= 1'b1;
    end else begin
      prevSave <= isSave;
      prevLoad <= isLoad;
      if (supplyLow)   pendingRecall <= 1'b1;
      else if (autoGo) pendingRecall <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (autoGo || loadGo) state <= ST_WIPE_WK;
          else if (saveGo)      state <= ST_WIPE_BK;
        end
        ST_WIPE_BK: begin
          if (wipeDone) begin state <= ST_SAVE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_SAVE: begin
          if (copyDone) begin state <= ST_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_WIPE_WK: begin
          if (wipeDone) begin state <= ST_LOAD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_LOAD: begin
          if (copyDone) begin state <= ST_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: begin state <= ST_IDLE; cnt <= '0; end
      endcase
    end
  end

  always_comb begin
    strobe.wkWrite  = isWrite && !blocked;
    strobe.bkWipe   = (state == ST_WIPE_BK) && (cnt == '0);
    strobe.wkWipe   = (state == ST_WIPE_WK) && (cnt == '0);
    strobe.saveByte = (state == ST_SAVE);
    strobe.loadByte = (state == ST_LOAD);
    xferAddr        = cnt[ADDR_W-1:0];
    readOn          = isRead && !blocked;
    busy            = !idle;
  end

endmodule

// File: rtl/nvsram_dp.sv
module nvsram_dp
  import nvsram_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PRELOAD_KEY = 'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] xferAddr,
  input  logic              readOn,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] workArr [DEPTH];
  logic [DATA_W-1:0] backArr [DEPTH];

  // working array: wipe, load from backup, or pin write
  always_ff @(posedge clk) begin
    if (strobe.wkWipe) begin
      for (int i = 0; i < DEPTH; i++) workArr[i] <= '0;
    end else if (strobe.loadByte) begin
      workArr[xferAddr] <= backArr[xferAddr];
    end else if (strobe.wkWrite) begin
      workArr[addr] <= din;
    end
  end

  // backup array: preload on reset, wipe, save from working
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++)
        backArr[i] <= DATA_W'(i) ^ DATA_W'(PRELOAD_KEY);
    end else if (strobe.bkWipe) begin
      for (int i = 0; i < DEPTH; i++) backArr[i] <= '0;
    end else if (strobe.saveByte) begin
      backArr[xferAddr] <= workArr[xferAddr];
    end
  end

  always_comb begin
    doutEn = readOn;
    dout   = readOn ? workArr[addr] : '0;
  end

endmodule

// File: rtl/nvsram_top.sv
module nvsram_top
  import nvsram_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 4,
  parameter int PRELOAD_KEY  = 'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              bkN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              supplyLow,
  input  logic              supplyGood,
  output logic [DATA_W-1:0] dout,
  output logic              doutEn,
  output logic              busy
);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] xferAddr;
  logic              readOn;
  logic              pendingRecall;

  nvsram_ctrl #(
    .ADDR_W(ADDR_W),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .csN(csN), .oeN(oeN), .weN(weN), .bkN(bkN),
    .supplyLow(supplyLow), .supplyGood(supplyGood),
    .strobe(strobe), .xferAddr(xferAddr),
    .readOn(readOn), .busy(busy), .pendingRecall(pendingRecall)
  );

  nvsram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PRELOAD_KEY(PRELOAD_KEY)
  ) u_dp (
    .clk(clk), .rst(rst),
    .strobe(strobe), .addr(addr), .din(din),
    .xferAddr(xferAddr), .readOn(readOn),
    .dout(dout), .doutEn(doutEn)
  );

endmodule

// File: rtl/nvsram_checker.sv
module nvsram_checker #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              csN,
  input logic              oeN,
  input logic              weN,
  input logic              bkN,
  input logic              supplyLow,
  input logic [DATA_W-1:0] dout,
  input logic              doutEn,
  input logic              busy,
  input logic              pendingRecall
);

  localparam int TOTAL = ERASE_CYCLES + (1 << ADDR_W);

  logic [3:0] pins;
  int         busyLen;

  assign pins = {csN, oeN, weN, bkN};

  always_ff @(posedge clk) begin
    if (rst) busyLen <= 0;
    else     busyLen <= busy ? busyLen + 1 : 0;
  end

  p_read_decode_r1: assert property (@(posedge clk) disable iff (rst)
    doutEn |-> (!csN && !oeN && weN && bkN));

  p_write_mutes_r2: assert property (@(posedge clk) disable iff (rst)
    (!csN && !weN) |-> !doutEn);

  p_dark_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !doutEn |-> (dout == '0));

  // covers both R4 and R5 sequence lengths
  p_seq_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busyLen == TOTAL));

  p_edge_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (($past(pins) != $past(pins, 2)) || $past(pendingRecall)));

  p_busy_dark_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !doutEn);

  p_arm_r9: assert property (@(posedge clk) disable iff (rst)
    supplyLow |=> pendingRecall);

  p_armed_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    pendingRecall |-> !doutEn);

endmodule

bind nvsram_top nvsram_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst),
  .csN(csN), .oeN(oeN), .weN(weN), .bkN(bkN),
  .supplyLow(supplyLow),
  .dout(dout), .doutEn(doutEn), .busy(busy),
  .pendingRecall(pendingRecall)
);

// File: tb/tb_nvsram_top.sv
module tb_nvsram_top;

  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int ER    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int TOTAL = ER + DEPTH;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csN = 1'b1, oeN = 1'b1, weN = 1'b1, bkN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din  = '0;
  logic          supplyLow = 1'b0, supplyGood = 1'b0;
  logic [DW-1:0] dout;
  logic          doutEn, busy;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  logic [DW-1:0] wkM [DEPTH];
  logic [DW-1:0] bkM [DEPTH];

  always #10 clk = ~clk;

  nvsram_top #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(ER)) dut (
    .clk(clk), .rst(rst),
    .csN(csN), .oeN(oeN), .weN(weN), .bkN(bkN),
    .addr(addr), .din(din),
    .supplyLow(supplyLow), .supplyGood(supplyGood),
    .dout(dout), .doutEn(doutEn), .busy(busy)
  );

  typedef struct packed {
    logic          c, o, w, n;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          expEn;
    logic [DW-1:0] expD;
  } vec_t;

  // working array holds (i mod 256) ^ 0xA5 when the table starts
  localparam vec_t VECS [12] = '{
    '{1'b0,1'b0,1'b1,1'b1, 11'h007, 8'h00, 1'b1, 8'hA2}, // R1 read
    '{1'b0,1'b0,1'b1,1'b1, 11'h7FF, 8'h00, 1'b1, 8'h5A}, // R1 top address
    '{1'b0,1'b0,1'b1,1'b1, 11'h000, 8'h00, 1'b1, 8'hA5}, // R1 bottom address
    '{1'b0,1'b1,1'b0,1'b1, 11'h007, 8'h3C, 1'b0, 8'h00}, // R2 write, oe high
    '{1'b0,1'b0,1'b0,1'b1, 11'h7FF, 8'hC3, 1'b0, 8'h00}, // R2 write, oe low
    '{1'b0,1'b0,1'b1,1'b1, 11'h007, 8'h00, 1'b1, 8'h3C}, // R2 readback
    '{1'b0,1'b0,1'b1,1'b1, 11'h7FF, 8'h00, 1'b1, 8'hC3}, // R2 readback
    '{1'b1,1'b0,1'b1,1'b1, 11'h007, 8'h00, 1'b0, 8'h00}, // R3 deselected
    '{1'b0,1'b1,1'b1,1'b1, 11'h007, 8'h00, 1'b0, 8'h00}, // R3 no op
    '{1'b0,1'b0,1'b1,1'b1, 11'h123, 8'h00, 1'b1, 8'h86}, // R1 middle
    '{1'b1,1'b1,1'b0,1'b1, 11'h123, 8'hFF, 1'b0, 8'h00}, // R3 write while deselected
    '{1'b0,1'b0,1'b1,1'b1, 11'h123, 8'h00, 1'b1, 8'h86}  // R3 byte untouched
  };

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic expOut(input string tag, input logic [DW-1:0] expD, input logic expEn);
    nChecks++;
    if (doutEn !== expEn || dout !== expD) begin
      nFail++;
      $display("FAIL %s: got en=%0b dout=%02h, expected en=%0b dout=%02h",
               tag, doutEn, dout, expEn, expD);
    end
  endtask

  task automatic expInt(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, o, w, n, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    csN = c; oeN = o; weN = w; bkN = n; addr = a; din = d;
    #2;
  endtask

  task automatic countBusy(output int cnt);
    cnt = 0;
    @(negedge clk);
    while (busy && cnt < 10000) begin
      cnt++;
      @(negedge clk);
    end
    #2;
  endtask

  task automatic modelSave();
    for (int i = 0; i < DEPTH; i++) bkM[i] = wkM[i];
  endtask

  task automatic modelLoad();
    for (int i = 0; i < DEPTH; i++) wkM[i] = bkM[i];
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: run did not finish, got hang, expected completion");
    finishRun();
  end

  initial begin
    int n;
    for (int i = 0; i < DEPTH; i++) bkM[i] = DW'(i) ^ 8'hA5;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R10: after reset, idle but the armed request blocks a read
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h000, 8'h00);
    expInt("R10 busy after reset", int'(busy), 0);
    expOut("R10 read blocked after reset", 8'h00, 1'b0);

    // R9: first good supply runs restore with read pins held
    @(negedge clk);
    supplyGood = 1'b1;
    countBusy(n);
    expInt("R9 automatic restore length", n, TOTAL);
    modelLoad();
    expOut("R10 preload visible at addr 0", 8'hA5, 1'b1);

    // vector table: R1 R2 R3
    for (int v = 0; v < 12; v++) begin
      drive(VECS[v].c, VECS[v].o, VECS[v].w, VECS[v].n, VECS[v].a, VECS[v].d);
      expOut($sformatf("table vector %0d (R1 R2 R3)", v), VECS[v].expD, VECS[v].expEn);
      if (!VECS[v].c && !VECS[v].w && VECS[v].n) wkM[VECS[v].a] = VECS[v].d;
    end

    // R4 save, pattern held throughout and afterwards (R6)
    drive(1'b0, 1'b1, 1'b0, 1'b0, 11'h000, 8'h00);
    countBusy(n);
    expInt("R4 save length", n, TOTAL);
    modelSave();
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, 1'b1, 1'b0, 1'b0, 11'h000, 8'h00);
      expInt("R6 held save pattern does not restart", int'(busy), 0);
    end

    // modify working data, then restore (R5)
    drive(1'b0, 1'b1, 1'b0, 1'b1, 11'h007, 8'h11);
    wkM[7] = 8'h11;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h007, 8'h00);
    expOut("R2 write before restore", wkM[7], 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 11'h007, 8'h00);
    countBusy(n);
    expInt("R5 restore length", n, TOTAL);
    modelLoad();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h007, 8'h00);
    expOut("R5 restored byte 7", wkM[7], 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h7FF, 8'h00);
    expOut("R5 restored top byte", wkM[11'h7FF], 1'b1);

    // R5 repeat: backup unchanged by previous restore
    drive(1'b0, 1'b1, 1'b0, 1'b1, 11'h007, 8'h55);
    wkM[7] = 8'h55;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 11'h007, 8'h00);
    countBusy(n);
    modelLoad();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h007, 8'h00);
    expOut("R5 second restore gives saved byte", 8'h3C, 1'b1);

    // R7 lock-out during a save, R8 read takes effect at completion
    drive(1'b0, 1'b1, 1'b0, 1'b0, 11'h000, 8'h00);
    n = 0;
    @(negedge clk);
    while (busy && n < 10000) begin
      if (n == 0) begin csN = 1'b0; oeN = 1'b1; weN = 1'b0; bkN = 1'b1; addr = 11'h020; din = 8'hEE; end
      if (n == 5) begin csN = 1'b0; oeN = 1'b0; weN = 1'b1; bkN = 1'b1; addr = 11'h007; din = 8'h00; end
      if (n == 2 || n == 100) begin
        #2;
        expOut("R7 output dark while busy", 8'h00, 1'b0);
      end
      n++;
      @(negedge clk);
    end
    #2;
    modelSave();
    expInt("R4 save length with pin activity", n, TOTAL);
    expOut("R8 read active on first free cycle", wkM[7], 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h020, 8'h00);
    expOut("R7 write during save ignored", wkM[11'h020], 1'b1);

    // R9 supply dip arms restore and blocks access
    drive(1'b0, 1'b1, 1'b0, 1'b1, 11'h007, 8'h77);
    wkM[7] = 8'h77;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h007, 8'h00);
    expOut("R2 write before dip", 8'h77, 1'b1);
    supplyLow = 1'b1;
    supplyGood = 1'b0;
    @(negedge clk);
    supplyLow = 1'b0;
    #2;
    expOut("R9 read blocked while armed", 8'h00, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h008, 8'h00);
    expOut("R9 still blocked, no restart without good", 8'h00, 1'b0);
    expInt("R9 no restore before good supply", int'(busy), 0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 11'h007, 8'h00);
    supplyGood = 1'b1;
    countBusy(n);
    expInt("R9 automatic restore after dip", n, TOTAL);
    modelLoad();
    expOut("R9 byte restored after dip, read immediate (R8)", wkM[7], 1'b1);

    finishRun();
  end

endmodule